// File: doc/BRIEF.md
# Timer Interrupt Flag Register Unit

This block keeps the interrupt flags of an eight-channel capture/compare timer. There is one sticky flag for each channel and one for counter overflow. The channel and counter logic raise a flag with a single-cycle event pulse. Software lowers flags in one of two ways:

- by writing ones into a flag register;
- when fast-clear is enabled, as a side effect of touching the channel data registers or the counter register.

The block watches a simple synchronous byte-wide register bus. It answers reads of its two flag registers with one cycle of latency. It combines each flag with its own enable into one interrupt line.

Each channel is marked as input capture or output compare by a per-channel mode input. The mode decides which kind of data-register access counts for fast-clear. The block only decodes the addresses of the channel data registers and the counter register. It does not hold their contents.

The bus is a plain strobe interface. It has no valid/ready handshake and applies no back-pressure: every strobe is accepted in the cycle it is presented. Default addresses are as follows:

| Register | Address |
|---|---|
| Channel flag register | 0x0E |
| Overflow flag register | 0x0F |
| Counter | 0x04 (high byte) and 0x05 (low byte) |
| Data register of channel n | 0x10+2n and 0x11+2n |

Top module: `tmr_flag_unit`

## Requirements
- R1: After reset, all channel flags and the overflow flag are 0, `irq` is 0 and `rd_data` is 0.
- R2: A pulse on `ch_evt[n]` sets channel flag n, which reads back in bit n of the channel flag register (0x0E). A pulse on `ovf_evt` sets the overflow flag, which reads back in bit 7 of the overflow flag register (0x0F). Bits 6..0 of 0x0F always read 0.
- R3: A read strobe returns the addressed flag register on `rd_data` in the next cycle. Reading either flag register never changes a flag.
- R4: A write to 0x0E clears each channel flag whose `wr_data` bit is 1 and leaves the flags whose bit is 0 unchanged. A write to 0x0F with bit 7 set clears the overflow flag, and bit 7 at 0 leaves it unchanged.
- R5: When a set event and any clear reach the same flag in the same cycle, the flag ends up set.
- R6: With `fast_clr_en`=1 and `ch_capture[n]`=1, a read of either byte of channel n's data register clears flag n. A write to it does not clear the flag.
- R7: With `fast_clr_en`=1 and `ch_capture[n]`=0, a write to either byte of channel n's data register clears flag n. A read of it does not clear the flag.
- R8: With `fast_clr_en`=1, a read or a write of either counter byte (0x04 or 0x05) clears the overflow flag.
- R9: With `fast_clr_en`=0, accesses to the channel data registers and the counter leave every flag unchanged.
- R10: `irq` is high exactly when some channel flag n is set with `ch_ie[n]`=1, or the overflow flag is set with `ovf_ie`=1.
- R11: A read of any address other than the two flag registers returns 0 on `rd_data` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Bus byte address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| fast_clr_en | input | 1 | Enables clearing of flags as a side effect of data and counter accesses |
| ch_capture | input | 8 | Per-channel mode: 1 = input capture, 0 = output compare |
| ch_evt | input | 8 | Per-channel single-cycle event pulses |
| ovf_evt | input | 1 | Counter overflow event pulse |
| ch_ie | input | 8 | Per-channel interrupt enables |
| ovf_ie | input | 1 | Overflow interrupt enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the unit with its default parameters: eight channels, an 8-bit address and the address map listed above. With these values every channel's flag bit and both bytes of every data register are reachable from the bench. So are both counter bytes and the bytes just above and below the decoded windows. Every flag bit position can therefore be checked against every access path that clears it, in both the capture and the compare mode.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
  localparam int BUS_W = 8;
  typedef logic [BUS_W-1:0] bus_byte_t;

  // Overflow flag lives in the MSB; the rest of the byte is zero.
  function automatic bus_byte_t ovf_to_byte(input logic f);
    return {f, {(BUS_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/tfu_addr_decode.sv
module tfu_addr_decode #(
  parameter int N_CH         = 8,
  parameter int ADDR_W       = 8,
  parameter int FLAG_CH_ADDR = 'h0E,
  parameter int FLAG_OV_ADDR = 'h0F,
  parameter int CNT_ADDR     = 'h04,
  parameter int CHDATA_BASE  = 'h10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              fast_clr_en,
  input  logic [N_CH-1:0]   ch_capture,
  output logic [N_CH-1:0]   ch_clr,
  output logic              ovf_clr,
  output logic              sel_flag_ch,
  output logic              sel_flag_ov
);
  localparam int PAIR_W = ADDR_W - 1;

  logic [N_CH-1:0] ch_hit;
  logic            cnt_hit;
  logic            acc;

  assign acc         = rd_en | wr_en;
  assign sel_flag_ch = (addr == ADDR_W'(FLAG_CH_ADDR));
  assign sel_flag_ov = (addr == ADDR_W'(FLAG_OV_ADDR));
  assign cnt_hit     = (addr[ADDR_W-1:1] == PAIR_W'(CNT_ADDR >> 1));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign ch_hit[i] = (addr[ADDR_W-1:1] == PAIR_W'((CHDATA_BASE >> 1) + i));
    always_comb begin
      ch_clr[i] = wr_en && sel_flag_ch && wr_data[i];
      if (fast_clr_en && ch_hit[i]) begin
        if (ch_capture[i]) ch_clr[i] = ch_clr[i] | rd_en;
        else               ch_clr[i] = ch_clr[i] | wr_en;
      end
    end
  end

  assign ovf_clr = (wr_en && sel_flag_ov && wr_data[7]) ||
                   (fast_clr_en && cnt_hit && acc);
endmodule

// File: rtl/tfu_flag_bank.sv
module tfu_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_o[b] <= 1'b0;
      else if (set_i[b]) flag_o[b] <= 1'b1;  // set beats clear
      else if (clr_i[b]) flag_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit #(
  parameter int N_CH         = 8,
  parameter int ADDR_W       = 8,
  parameter int FLAG_CH_ADDR = 'h0E,
  parameter int FLAG_OV_ADDR = 'h0F,
  parameter int CNT_ADDR     = 'h04,
  parameter int CHDATA_BASE  = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              fast_clr_en,
  input  logic [N_CH-1:0]   ch_capture,
  input  logic [N_CH-1:0]   ch_evt,
  input  logic              ovf_evt,
  input  logic [N_CH-1:0]   ch_ie,
  input  logic              ovf_ie,
  output logic              irq
);
  import tfu_pkg::*;

  logic [N_CH-1:0] ch_clr;
  logic [N_CH-1:0] ch_flag;
  logic            ovf_clr;
  logic [0:0]      ovf_flag;
  logic            sel_flag_ch;
  logic            sel_flag_ov;
  bus_byte_t       rd_next;

  tfu_addr_decode #(
    .N_CH(N_CH), .ADDR_W(ADDR_W), .FLAG_CH_ADDR(FLAG_CH_ADDR),
    .FLAG_OV_ADDR(FLAG_OV_ADDR), .CNT_ADDR(CNT_ADDR), .CHDATA_BASE(CHDATA_BASE)
  ) i_dec (
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .fast_clr_en(fast_clr_en), .ch_capture(ch_capture),
    .ch_clr(ch_clr), .ovf_clr(ovf_clr),
    .sel_flag_ch(sel_flag_ch), .sel_flag_ov(sel_flag_ov)
  );

  tfu_flag_bank #(.W(N_CH)) i_ch_bank (
    .clk(clk), .rst_n(rst_n), .set_i(ch_evt), .clr_i(ch_clr), .flag_o(ch_flag)
  );

  tfu_flag_bank #(.W(1)) i_ov_bank (
    .clk(clk), .rst_n(rst_n), .set_i(ovf_evt), .clr_i(ovf_clr), .flag_o(ovf_flag)
  );

  always_comb begin
    rd_next = '0;
    if (sel_flag_ch)      rd_next = BUS_W'(ch_flag);
    else if (sel_flag_ov) rd_next = ovf_to_byte(ovf_flag[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  assign irq = (|(ch_flag & ch_ie)) | (ovf_flag[0] & ovf_ie);
endmodule

// File: rtl/tmr_flag_unit_chk.sv
module tmr_flag_unit_chk #(
  parameter int N_CH         = 8,
  parameter int ADDR_W       = 8,
  parameter int FLAG_CH_ADDR = 'h0E
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              fast_clr_en,
  input logic [N_CH-1:0]   ch_evt,
  input logic              ovf_evt,
  input logic [N_CH-1:0]   ch_flag,
  input logic              ovf_flag,
  input logic              irq
);
  logic ch_wr;
  assign ch_wr = wr_en && (addr == ADDR_W'(FLAG_CH_ADDR));

  // R2, R5: an event always leaves its flag set
  a_r5_ch_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_evt) |=> ((ch_flag & $past(ch_evt)) == $past(ch_evt)));

  a_r2_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);

  // R4: zero bits of a flag write keep their flags
  a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_wr && !fast_clr_en) |=>
      ((ch_flag & $past(ch_flag) & ~$past(wr_data[N_CH-1:0])) ==
       ($past(ch_flag) & ~$past(wr_data[N_CH-1:0]))));

  // R4: one bits clear unless an event hits the same bit
  a_r4_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ch_wr |=> ((ch_flag & $past(wr_data[N_CH-1:0]) & ~$past(ch_evt)) == '0));

  // R9: with fast-clear off and no flag write, channel flags never drop
  a_r9_no_fastclr: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_clr_en && !ch_wr) |=> ((ch_flag & $past(ch_flag)) == $past(ch_flag)));

  // R10: interrupt needs a pending flag
  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|ch_flag) || ovf_flag));
endmodule

bind tmr_flag_unit tmr_flag_unit_chk #(
  .N_CH(N_CH), .ADDR_W(ADDR_W), .FLAG_CH_ADDR(FLAG_CH_ADDR)
) i_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .fast_clr_en(fast_clr_en), .ch_evt(ch_evt), .ovf_evt(ovf_evt),
  .ch_flag(ch_flag), .ovf_flag(ovf_flag[0]), .irq(irq)
);

// File: tb/test_tmr_flag_unit.sv
`timescale 1ns/1ps
module test_tmr_flag_unit;
  localparam logic [7:0] A_FCH = 8'h0E, A_FOV = 8'h0F, A_CNT = 8'h04, A_DAT = 8'h10;

  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wr_data = 0, ch_capture = 0, ch_evt = 0, ch_ie = 0;
  logic rd_en = 0, wr_en = 0, fast_clr_en = 0, ovf_evt = 0, ovf_ie = 0;
  logic [7:0] rd_data;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_flag_unit i_tmr_flag_unit (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .fast_clr_en(fast_clr_en),
    .ch_capture(ch_capture), .ch_evt(ch_evt), .ovf_evt(ovf_evt),
    .ch_ie(ch_ie), .ovf_ie(ovf_ie), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic pulse(input logic [7:0] ce, input logic oe);
    @(negedge clk); ch_evt = ce; ovf_evt = oe;
    @(negedge clk); ch_evt = 0; ovf_evt = 0;
  endtask

  task automatic clear_all();
    bus_wr(A_FCH, 8'hFF); bus_wr(A_FOV, 8'h80);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    bus_rd(A_FCH, d); chk("R1 ch flags", d, 8'h00);
    bus_rd(A_FOV, d); chk("R1 ovf flag", d, 8'h00);
  endtask

  task automatic t_set_read();
    logic [7:0] d;
    pulse(8'hA5, 1'b0);
    bus_rd(A_FCH, d); chk("R2 set A5", d, 8'hA5);
    pulse(8'h5A, 1'b1);
    bus_rd(A_FCH, d); chk("R2 set FF", d, 8'hFF);
    bus_rd(A_FOV, d); chk("R2 ovf bit7 only", d, 8'h80);
    bus_rd(A_FCH, d); chk("R3 read no clear", d, 8'hFF);
    bus_rd(8'h00, d); chk("R11 unmapped", d, 8'h00);
    bus_rd(8'h12, d); chk("R11 data addr reads 0", d, 8'h00);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    bus_wr(A_FCH, 8'h00);
    bus_rd(A_FCH, d); chk("R4 zero write", d, 8'hFF);
    bus_wr(A_FCH, 8'h81);
    bus_rd(A_FCH, d); chk("R4 clear 81", d, 8'h7E);
    bus_wr(A_FOV, 8'h7F);
    bus_rd(A_FOV, d); chk("R4 ovf bit7 zero", d, 8'h80);
    bus_wr(A_FOV, 8'h80);
    bus_rd(A_FOV, d); chk("R4 ovf clear", d, 8'h00);
    clear_all();
    bus_rd(A_FCH, d); chk("R4 clear all", d, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    pulse(8'h04, 1'b1);
    @(negedge clk); addr = A_FCH; wr_data = 8'h04; wr_en = 1; ch_evt = 8'h04;
    @(negedge clk); wr_en = 0; ch_evt = 0;
    bus_rd(A_FCH, d); chk("R5 ch set wins", d, 8'h04);
    fast_clr_en = 1;
    @(negedge clk); addr = A_CNT; rd_en = 1; ovf_evt = 1;
    @(negedge clk); rd_en = 0; ovf_evt = 0;
    bus_rd(A_FOV, d); chk("R5 ovf set wins", d, 8'h80);
    fast_clr_en = 0;
    clear_all();
  endtask

  task automatic t_fast_capture();
    logic [7:0] d;
    fast_clr_en = 1; ch_capture = 8'hFF;
    pulse(8'hFF, 1'b0);
    bus_wr(A_DAT + 8'd6, 8'h11);
    bus_rd(A_FCH, d); chk("R6 write ignored", d, 8'hFF);
    bus_rd(A_DAT + 8'd6, d);
    bus_rd(A_FCH, d); chk("R6 read hi clears ch3", d, 8'hF7);
    bus_rd(A_DAT + 8'd15, d);
    bus_rd(A_FCH, d); chk("R6 read lo clears ch7", d, 8'h77);
    bus_rd(A_DAT + 8'd1, d);
    bus_rd(A_FCH, d); chk("R6 read clears ch0", d, 8'h76);
    bus_rd(8'h20, d);
    bus_rd(A_FCH, d); chk("R6 above window", d, 8'h76);
    fast_clr_en = 0; clear_all();
  endtask

  task automatic t_fast_compare();
    logic [7:0] d;
    fast_clr_en = 1; ch_capture = 8'h00;
    pulse(8'hFF, 1'b0);
    bus_rd(A_DAT + 8'd4, d);
    bus_rd(A_FCH, d); chk("R7 read ignored", d, 8'hFF);
    bus_wr(A_DAT + 8'd5, 8'h00);
    bus_rd(A_FCH, d); chk("R7 write clears ch2", d, 8'hFB);
    bus_wr(A_DAT + 8'd12, 8'h00);
    bus_rd(A_FCH, d); chk("R7 write clears ch6", d, 8'hBB);
    fast_clr_en = 0; clear_all();
  endtask

  task automatic t_fast_counter();
    logic [7:0] d;
    fast_clr_en = 1;
    pulse(8'h00, 1'b1);
    bus_rd(A_CNT, d);
    bus_rd(A_FOV, d); chk("R8 read cnt hi", d, 8'h00);
    pulse(8'h00, 1'b1);
    bus_wr(A_CNT + 8'd1, 8'h00);
    bus_rd(A_FOV, d); chk("R8 write cnt lo", d, 8'h00);
    pulse(8'h00, 1'b1);
    bus_rd(8'h03, d);
    bus_rd(A_FOV, d); chk("R8 below cnt", d, 8'h80);
    fast_clr_en = 0; clear_all();
  endtask

  task automatic t_fast_off();
    logic [7:0] d;
    fast_clr_en = 0; ch_capture = 8'h0F;
    pulse(8'hFF, 1'b1);
    for (int c = 0; c < 8; c++) begin
      bus_rd(A_DAT + 8'(2*c), d);
      bus_wr(A_DAT + 8'(2*c+1), 8'h00);
    end
    bus_rd(A_CNT, d); bus_wr(A_CNT + 8'd1, 8'h00);
    bus_rd(A_FCH, d); chk("R9 ch flags kept", d, 8'hFF);
    bus_rd(A_FOV, d); chk("R9 ovf kept", d, 8'h80);
    clear_all();
  endtask

  task automatic t_irq();
    pulse(8'h10, 1'b0);
    ch_ie = 8'hEF; @(negedge clk);
    chk("R10 masked", {7'b0, irq}, 8'h00);
    ch_ie = 8'h10; @(negedge clk);
    chk("R10 enabled", {7'b0, irq}, 8'h01);
    bus_wr(A_FCH, 8'h10);
    chk("R10 cleared", {7'b0, irq}, 8'h00);
    pulse(8'h00, 1'b1);
    chk("R10 ovf masked", {7'b0, irq}, 8'h00);
    ovf_ie = 1; @(negedge clk);
    chk("R10 ovf enabled", {7'b0, irq}, 8'h01);
    ovf_ie = 0; ch_ie = 0; clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_set_read();
    t_w1c();
    t_set_wins();
    t_fast_capture();
    t_fast_compare();
    t_fast_counter();
    t_fast_off();
    t_irq();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule